// File: doc/BRIEF.md
# Scanline Line-Segment Rasterizer

This block draws a set of straight line segments onto a display one row at a time. It keeps no framebuffer. A small segment table stores each segment's starting column, first row, last row and a signed slope coefficient, which is computed ahead of time outside the block. When a row is requested, the block first zeroes a one-row pixel buffer. It then visits every active segment and works out which columns that segment covers on the requested row. It sets those pixels in the buffer and finally hands the buffer to a downstream FIFO as 16-bit words.

A column is computed with one multiply followed by a power-of-two divide, done as an arithmetic right shift. A segment covers the columns between its position on the current row and its position on the next row. This keeps shallow segments free of gaps. All span work for a row must fit inside a cycle budget that matches the horizontal blanking time. If a row runs past that budget, a sticky flag records the overrun.

Top module: `scanline_raster`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `fifo_push`, `row_done` and `overrun` are all 0 until a row is requested.
- R2: A `row_start` pulse in an idle cycle latches `row_y` and starts a row. A `row_start` pulse while `busy` is high is ignored: the row in progress keeps its row number and its timing.
- R3: Every row starts by clearing the whole pixel buffer, so pixels drawn on an earlier row never appear in a later one.
- R4: Only table entries 0 to `seg_count`-1 are visited. Such an entry contributes to row Y only when its first row is at most Y and Y is at most its last row.
- R5: A segment's column on row Y is x0 + floor((Y - y0) * A / 2^FRAC), where A is the slope coefficient in two's complement.
- R6: Below its last row, a segment sets every column from its column on Y to its column on Y+1, inclusive and in either order. On its last row it sets only its column on Y. Spans are clipped to 0..LINE_PIX-1, and a span lying fully outside that range sets nothing.
- R7: The buffer leaves as LINE_PIX/16 words, in order from word 0 upward. Column 16*w+k appears in word w at bit 15-k, so the leftmost pixel is the MSB.
- R8: `fifo_push` is high only in cycles where `fifo_full` is low. While `fifo_full` is high the pending word is held unchanged.
- R9: `row_done` is high for exactly one cycle, the cycle after the last word of the row is pushed.
- R10: After `row_start` is sampled, the clear takes LINE_PIX/16 cycles. The span phase then takes `seg_count` + 1 cycles plus one cycle for each buffer word touched by each visible span. The first push is offered in the cycle right after the span phase.
- R11: `overrun` becomes 1 when a row's span phase lasts more than BUDGET cycles, and it stays at 1 until reset.
- R12: A write on the segment port stores x0, y0, y1 and A at the given table index, and later rows use the stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_wr_en | input | 1 | Write one segment table entry |
| seg_wr_idx | input | clog2(NSEG) | Table index to write |
| seg_wr_x0 | input | XW | Starting column |
| seg_wr_y0 | input | YW | First row |
| seg_wr_y1 | input | YW | Last row |
| seg_wr_slope | input | CW | Signed slope coefficient A |
| seg_count | input | clog2(NSEG)+1 | Number of active entries |
| row_start | input | 1 | Request rendering of a row |
| row_y | input | YW | Row number to render |
| fifo_full | input | 1 | Downstream FIFO cannot accept a word |
| fifo_push | output | 1 | Word on fifo_data is written this cycle |
| fifo_data | output | 16 | Packed pixel word |
| row_done | output | 1 | Row finished pulse |
| busy | output | 1 | Row in progress |
| overrun | output | 1 | Sticky span-budget overrun flag |

## Verification
The reference model counts cycles from the clock edge that samples `row_start`. It expects the clear to end LINE_PIX/16 cycles later. It then expects the span phase to last `seg_count` + 1 cycles plus the fill words of the visible spans. Pushes are expected in every following cycle where `fifo_full` is low, and `row_done` exactly one cycle after the last push. The overrun flag is expected one cycle after span-phase cycle BUDGET+1. Inputs change just after a rising edge, and all outputs are compared against the model on the falling edge. Each comparison therefore sees settled values for the cycle the model is describing.

// File: rtl/scanline_raster_pkg.sv
package scanline_raster_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CLEAR, ST_SPAN, ST_FILL, ST_PUSH, ST_DONE
  } rstate_t;
  localparam int PIX_PER_WORD = 16;
endpackage

// File: rtl/raster_seg_mem.sv
module raster_seg_mem #(
  parameter int NSEG = 256,
  parameter int XW   = 10,
  parameter int YW   = 10,
  parameter int CW   = 16,
  localparam int IW  = $clog2(NSEG)
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic [XW-1:0]        wr_x0,
  input  logic [YW-1:0]        wr_y0,
  input  logic [YW-1:0]        wr_y1,
  input  logic signed [CW-1:0] wr_slope,
  input  logic [IW-1:0]        rd_idx,
  output logic [XW-1:0]        rd_x0,
  output logic [YW-1:0]        rd_y0,
  output logic [YW-1:0]        rd_y1,
  output logic signed [CW-1:0] rd_slope
);
  logic [XW-1:0]        x0_mem [NSEG];
  logic [YW-1:0]        y0_mem [NSEG];
  logic [YW-1:0]        y1_mem [NSEG];
  logic signed [CW-1:0] a_mem  [NSEG];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      x0_mem[wr_idx] <= wr_x0;
      y0_mem[wr_idx] <= wr_y0;
      y1_mem[wr_idx] <= wr_y1;
      a_mem[wr_idx]  <= wr_slope;
    end
  end

  assign rd_x0    = x0_mem[rd_idx];
  assign rd_y0    = y0_mem[rd_idx];
  assign rd_y1    = y1_mem[rd_idx];
  assign rd_slope = a_mem[rd_idx];
endmodule

// File: rtl/raster_span_calc.sv
module raster_span_calc #(
  parameter int XW       = 10,
  parameter int YW       = 10,
  parameter int CW       = 16,
  parameter int FRAC     = 8,
  parameter int LINE_PIX = 640
) (
  input  logic [YW-1:0]        row_y,
  input  logic [XW-1:0]        seg_x0,
  input  logic [YW-1:0]        seg_y0,
  input  logic [YW-1:0]        seg_y1,
  input  logic signed [CW-1:0] seg_slope,
  output logic                 hit,
  output logic [XW-1:0]        lo,
  output logic [XW-1:0]        hi
);
  localparam int SW = YW + CW + XW + 3;
  logic signed [SW-1:0] dy_now, dy_next, slope_w, base, xa, xb, smin, smax, last_col;
  logic active;

  always_comb begin
    active   = (row_y >= seg_y0) && (row_y <= seg_y1);
    dy_now   = $signed(SW'(row_y)) - $signed(SW'(seg_y0));
    dy_next  = dy_now + $signed(SW'(1));
    slope_w  = SW'(seg_slope);
    base     = $signed(SW'(seg_x0));
    last_col = $signed(SW'(LINE_PIX - 1));
    xa       = base + ((dy_now * slope_w) >>> FRAC);
    xb       = (row_y < seg_y1) ? base + ((dy_next * slope_w) >>> FRAC) : xa;
    smin     = (xa < xb) ? xa : xb;
    smax     = (xa < xb) ? xb : xa;
    hit      = active && (smax >= 0) && (smin <= last_col);
    lo       = (smin < 0) ? '0 : XW'(smin);
    hi       = (smax > last_col) ? XW'(LINE_PIX - 1) : XW'(smax);
  end
endmodule

// File: rtl/raster_line_buf.sv
module raster_line_buf #(
  parameter int WORDS = 40,
  parameter int XW    = 10,
  localparam int WIX  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic           clk,
  input  logic           clr,
  input  logic           fill,
  input  logic [WIX-1:0] idx,
  input  logic [XW-1:0]  lo,
  input  logic [XW-1:0]  hi,
  output logic [15:0]    rd_data
);
  logic [15:0] line_mem [WORDS];
  logic [15:0] mask;

  always_comb begin
    for (int b = 0; b < 16; b++) begin
      mask[b] = ((int'(idx) * 16 + 15 - b) >= int'(lo)) &&
                ((int'(idx) * 16 + 15 - b) <= int'(hi));
    end
  end

  always_ff @(posedge clk) begin
    if (clr)       line_mem[idx] <= '0;
    else if (fill) line_mem[idx] <= line_mem[idx] | mask;
  end

  assign rd_data = line_mem[idx];
endmodule

// File: rtl/scanline_raster.sv
module scanline_raster
  import scanline_raster_pkg::*;
#(
  parameter int LINE_PIX = 640,
  parameter int NSEG     = 256,
  parameter int XW       = 10,
  parameter int YW       = 10,
  parameter int CW       = 16,
  parameter int FRAC     = 8,
  parameter int BUDGET   = 800
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      seg_wr_en,
  input  logic [$clog2(NSEG)-1:0]   seg_wr_idx,
  input  logic [XW-1:0]             seg_wr_x0,
  input  logic [YW-1:0]             seg_wr_y0,
  input  logic [YW-1:0]             seg_wr_y1,
  input  logic signed [CW-1:0]      seg_wr_slope,
  input  logic [$clog2(NSEG):0]     seg_count,
  input  logic                      row_start,
  input  logic [YW-1:0]             row_y,
  input  logic                      fifo_full,
  output logic                      fifo_push,
  output logic [15:0]               fifo_data,
  output logic                      row_done,
  output logic                      busy,
  output logic                      overrun
);
  localparam int WORDS = LINE_PIX / PIX_PER_WORD;
  localparam int WIX   = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int IW    = $clog2(NSEG);
  localparam int BW    = $clog2(BUDGET + 2);

  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rst_meta <= 1'b0; rst_n_s <= 1'b0; end
    else        begin rst_meta <= 1'b1; rst_n_s <= rst_meta; end
  end

  rstate_t        state_q, state_d;
  logic [YW-1:0]  y_q, y_d;
  logic [WIX-1:0] word_q, word_d;
  logic [IW:0]    seg_q, seg_d;
  logic [XW-1:0]  lo_q, lo_d, hi_q, hi_d;
  logic [BW-1:0]  bud_q, bud_d;
  logic           ovr_q, ovr_d;
  logic           buf_clr, buf_fill;

  logic [XW-1:0]        m_x0;
  logic [YW-1:0]        m_y0, m_y1;
  logic signed [CW-1:0] m_a;
  logic                 span_hit;
  logic [XW-1:0]        span_lo, span_hi;
  logic [WIX-1:0]       hi_wd;

  raster_seg_mem #(.NSEG(NSEG), .XW(XW), .YW(YW), .CW(CW)) u_mem (
    .clk(clk), .wr_en(seg_wr_en), .wr_idx(seg_wr_idx), .wr_x0(seg_wr_x0),
    .wr_y0(seg_wr_y0), .wr_y1(seg_wr_y1), .wr_slope(seg_wr_slope),
    .rd_idx(seg_q[IW-1:0]), .rd_x0(m_x0), .rd_y0(m_y0), .rd_y1(m_y1), .rd_slope(m_a)
  );

  raster_span_calc #(.XW(XW), .YW(YW), .CW(CW), .FRAC(FRAC), .LINE_PIX(LINE_PIX)) u_span (
    .row_y(y_q), .seg_x0(m_x0), .seg_y0(m_y0), .seg_y1(m_y1), .seg_slope(m_a),
    .hit(span_hit), .lo(span_lo), .hi(span_hi)
  );

  raster_line_buf #(.WORDS(WORDS), .XW(XW)) u_line (
    .clk(clk), .clr(buf_clr), .fill(buf_fill), .idx(word_q),
    .lo(lo_q), .hi(hi_q), .rd_data(fifo_data)
  );

  assign hi_wd = WIX'(hi_q >> 4);

  always_comb begin
    state_d = state_q; y_d = y_q; word_d = word_q; seg_d = seg_q;
    lo_d = lo_q; hi_d = hi_q; bud_d = bud_q; ovr_d = ovr_q;
    buf_clr = 1'b0; buf_fill = 1'b0;
    unique case (state_q)
      ST_IDLE: if (row_start) begin
        y_d = row_y; word_d = '0; state_d = ST_CLEAR;
      end
      ST_CLEAR: begin
        buf_clr = 1'b1;
        if (word_q == WIX'(WORDS - 1)) begin
          word_d = '0; seg_d = '0; bud_d = '0; state_d = ST_SPAN;
        end else word_d = word_q + 1'b1;
      end
      ST_SPAN: begin
        if (seg_q >= seg_count) begin
          word_d = '0; state_d = ST_PUSH;
        end else if (span_hit) begin
          lo_d = span_lo; hi_d = span_hi;
          word_d = WIX'(span_lo >> 4); state_d = ST_FILL;
        end else seg_d = seg_q + 1'b1;
      end
      ST_FILL: begin
        buf_fill = 1'b1;
        if (word_q == hi_wd) begin
          seg_d = seg_q + 1'b1; state_d = ST_SPAN;
        end else word_d = word_q + 1'b1;
      end
      ST_PUSH: if (!fifo_full) begin
        if (word_q == WIX'(WORDS - 1)) state_d = ST_DONE;
        else word_d = word_q + 1'b1;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (state_q == ST_SPAN || state_q == ST_FILL) begin
      if (bud_q == BW'(BUDGET)) ovr_d = 1'b1;
      else bud_d = bud_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE; y_q <= '0; word_q <= '0; seg_q <= '0;
      lo_q <= '0; hi_q <= '0; bud_q <= '0; ovr_q <= 1'b0;
    end else begin
      state_q <= state_d; y_q <= y_d; word_q <= word_d; seg_q <= seg_d;
      lo_q <= lo_d; hi_q <= hi_d; bud_q <= bud_d; ovr_q <= ovr_d;
    end
  end

  assign fifo_push = (state_q == ST_PUSH) && !fifo_full;
  assign row_done  = (state_q == ST_DONE);
  assign busy      = (state_q != ST_IDLE);
  assign overrun   = ovr_q;

  // R9: the done pulse follows a push
  a_r9_done_after_push: assert property (@(posedge clk) disable iff (!rst_n_s)
    row_done |-> $past(fifo_push));
  // R11: overrun never clears outside reset
  a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(overrun) |-> overrun);
  // R8: a stalled word stays on the output
  a_r8_stall_holds_word: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(state_q == ST_PUSH && fifo_full) |-> (state_q == ST_PUSH && $stable(fifo_data)));
  // R2: the row number is frozen while a row is in progress
  a_r2_row_locked: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q != ST_IDLE) |=> $stable(y_q));
  // R6: the fill pointer stays inside the latched span
  a_r6_fill_in_span: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_FILL) |-> (word_q >= WIX'(lo_q >> 4) && word_q <= hi_wd));
endmodule

// File: tb/scanline_raster_bench.sv
module scanline_raster_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LP = 64, NS = 8, XW = 10, YW = 8, CW = 12, FR = 4, BUD = 12;
  localparam int WORDS = LP / 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic seg_wr_en = 1'b0;
  logic [2:0] seg_wr_idx = '0;
  logic [XW-1:0] seg_wr_x0 = '0;
  logic [YW-1:0] seg_wr_y0 = '0, seg_wr_y1 = '0;
  logic signed [CW-1:0] seg_wr_slope = '0;
  logic [3:0] seg_count = '0;
  logic row_start = 1'b0;
  logic [YW-1:0] row_y = '0;
  logic fifo_full = 1'b0;
  logic fifo_push, row_done, busy, overrun;
  logic [15:0] fifo_data;

  scanline_raster #(.LINE_PIX(LP), .NSEG(NS), .XW(XW), .YW(YW), .CW(CW),
                    .FRAC(FR), .BUDGET(BUD)) u_scanline_raster (
    .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_wr_idx(seg_wr_idx),
    .seg_wr_x0(seg_wr_x0), .seg_wr_y0(seg_wr_y0), .seg_wr_y1(seg_wr_y1),
    .seg_wr_slope(seg_wr_slope), .seg_count(seg_count), .row_start(row_start),
    .row_y(row_y), .fifo_full(fifo_full), .fifo_push(fifo_push),
    .fifo_data(fifo_data), .row_done(row_done), .busy(busy), .overrun(overrun));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, n_push = 0;
  int m_x0[NS], m_y0[NS], m_y1[NS], m_a[NS];
  int ms = 0, m_rem = 0, m_phase = 0, m_p = 0, m_pi = 0, m_ovr = 0;
  logic [15:0] exp_w[WORDS];

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural row model: pixel list plus span-phase length (R3..R7, R10, R12)
  task automatic compute_row(input int y);
    bit pix[LP];
    int xa, xb, lo, hi;
    for (int i = 0; i < LP; i++) pix[i] = 0;
    m_p = int'(seg_count) + 1;
    for (int s = 0; s < int'(seg_count); s++) begin
      if (y >= m_y0[s] && y <= m_y1[s]) begin
        xa = m_x0[s] + (((y - m_y0[s]) * m_a[s]) >>> FR);
        xb = (y < m_y1[s]) ? m_x0[s] + (((y + 1 - m_y0[s]) * m_a[s]) >>> FR) : xa;
        lo = (xa < xb) ? xa : xb;
        hi = (xa < xb) ? xb : xa;
        if (hi >= 0 && lo <= LP - 1) begin
          if (lo < 0) lo = 0;
          if (hi > LP - 1) hi = LP - 1;
          for (int p = lo; p <= hi; p++) pix[p] = 1;
          m_p += hi / 16 - lo / 16 + 1;
        end
      end
    end
    for (int w = 0; w < WORDS; w++)
      for (int k = 0; k < 16; k++) exp_w[w][15-k] = pix[w*16+k];
  endtask

  always @(negedge clk) begin
    chk("R1 R2 R10 busy", int'(busy), int'(ms != 0));
    chk("R8 R10 fifo_push", int'(fifo_push), int'(ms == 3 && !fifo_full));
    if (ms == 3 && !fifo_full)
      chk("R3 R4 R5 R6 R7 fifo_data", int'(fifo_data), int'(exp_w[m_pi]));
    chk("R9 row_done", int'(row_done), int'(ms == 4));
    chk("R11 overrun", int'(overrun), m_ovr);
    if (fifo_push) n_push++;
    case (ms)
      0: if (row_start && rst_n) begin compute_row(int'(row_y)); ms = 1; m_rem = WORDS; end
      1: begin m_rem--; if (m_rem == 0) begin ms = 2; m_phase = 0; end end
      2: begin
        m_phase++;
        if (m_phase == BUD + 1) m_ovr = 1;
        if (m_phase == m_p) begin ms = 3; m_pi = 0; end
      end
      3: if (!fifo_full) begin m_pi++; if (m_pi == WORDS) ms = 4; end
      default: ms = 0;
    endcase
  end

  task automatic wr_seg(input int i, input int x0, input int y0, input int y1, input int a);
    @(posedge clk); #1;
    seg_wr_en = 1'b1; seg_wr_idx = 3'(i); seg_wr_x0 = XW'(x0);
    seg_wr_y0 = YW'(y0); seg_wr_y1 = YW'(y1); seg_wr_slope = CW'(a);
    m_x0[i] = x0; m_y0[i] = y0; m_y1[i] = y1; m_a[i] = a;
    @(posedge clk); #1; seg_wr_en = 1'b0;
  endtask

  task automatic run_row(input int y, input int mode);
    @(posedge clk); #1; row_y = YW'(y); row_start = 1'b1;
    for (int cyc = 0; cyc < 200; cyc++) begin
      @(posedge clk); #1;
      if (row_done) break;
      row_start = (cyc == 4);          // R2: retrigger while busy, must be ignored
      if (cyc == 4) row_y = YW'(y + 1);
      fifo_full = (mode == 1) ? (cyc % 3 == 0) : (mode == 2) ? (cyc % 5 < 3) : 1'b0;
    end
    row_start = 1'b0; fifo_full = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset overrun", int'(overrun), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R12: load table, then render with all or part of it active
    wr_seg(0, 5, 10, 11, 640);
    wr_seg(1, 30, 0, 20, 0);
    wr_seg(2, 60, 5, 15, -40);
    wr_seg(3, 50, 10, 12, 320);
    wr_seg(4, 100, 0, 40, 0);
    wr_seg(5, 2, 25, 35, -24);
    seg_count = 4'd6;
    run_row(3, 0);
    run_row(11, 1);
    run_row(30, 2);
    run_row(25, 0);
    chk("R11 no overrun within budget", int'(overrun), 0);
    seg_count = 4'd1;
    run_row(10, 0);
    seg_count = 4'd6;
    run_row(10, 1);
    chk("R11 overrun set", int'(overrun), 1);
    run_row(11, 0);
    chk("R11 overrun kept", int'(overrun), 1);
    chk("R7 total words pushed", n_push, 7 * WORDS);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule